// File: doc/BRIEF.md
# Retriggerable Watchdog Interval Timer

This block is a BCD down-counter that counts 100 Hz ticks. Two byte registers hold the interval in hundredths of a second, as four BCD digits. The low byte holds hundredths and tenths. The high byte holds units and tens of seconds. Together they set an interval from 00.01 s to 99.99 s.

When the count runs out, the block sets a timeout flag and reloads the programmed interval, so it keeps firing at a fixed period. The flag drives an interrupt request, which a mask bit can hold off. Software that writes either interval byte restarts the whole countdown and drops a pending timeout. Used this way the block is a processor watchdog: firmware that stops rewriting the interval lets the timer expire.

A third address is a control byte. Bit 0 is the mask and is writable. Bit 1 is the timeout flag and is read-only. Reading the control byte acknowledges, and so clears, the flag.

Top module: `wdt_interval_timer`

## Requirements
- R1: After reset, both interval bytes read 0x00, the control byte reads 0x01 (mask set, flag clear), and `irq` is low.
- R2: A write to address 0 (low byte) or address 1 (high byte) stores the byte, and a read at that address returns it.
- R3: With interval N hundredths, `timeout_flag` stays low through the first N-1 ticks after a load and is high on the clock edge of the Nth tick.
- R4: The count borrows in BCD from digit to digit, so intervals such as 00.10, 01.00, 02.50, 10.00 and 99.99 take exactly 10, 100, 250, 1000 and 9999 ticks.
- R5: On timeout the counter reloads the programmed interval, and the next timeout comes after another N ticks.
- R6: A write to either interval byte reloads the counter from both bytes and clears `timeout_flag` on the same edge.
- R7: While both interval bytes are zero, no number of ticks ever sets `timeout_flag`.
- R8: A read of the control byte (address 2) returns {6'b0, flag, mask} and clears the flag on that edge.
- R9: `irq` is high exactly when the flag is set and control bit 0 (mask) is 0.
- R10: A write to the control byte changes only the mask. It neither restarts the count nor alters the flag.
- R11: A tick in the same cycle as an interval write is not counted; the write's reload takes precedence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse at 100 Hz |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read of address 2 clears the flag) |
| addr | input | AW (2) | Register address: 0 low interval byte, 1 high interval byte, 2 control |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational from the address |
| timeout_flag | output | 1 | Timeout flag |
| irq | output | 1 | Interrupt request, flag gated by the mask |

## Verification
A wrong digit or a broken borrow inside the counter shows no output of its own. It appears only as a timeout on the wrong tick. That can be hundreds or thousands of ticks after the fault, so each interval is timed over its whole length to the exact tick, and timed twice to cover the reload. A flag that sets or clears wrongly shows at once on `timeout_flag`, on `irq`, and in the control byte read back on the next cycle.

// File: rtl/wdt_pkg.sv
// Package: shared constants for the watchdog interval timer.
// Assumes byte-wide registers holding two BCD digits each.
package wdt_pkg;
    localparam int DIGIT_W       = 4;
    localparam int BYTE_W        = 8;
    localparam int CTRL_MASK_BIT = 0;
    localparam int CTRL_FLAG_BIT = 1;
    localparam logic [3:0] BCD_MAX = 4'd9;
endpackage

// File: rtl/wdt_bcd_counter.sv
// Loadable BCD down-counter of NDIG digits.
// Decrements by one count per dec pulse, with a borrow rippling through the digits.
// Assumes the loaded value is valid BCD. load takes precedence over dec.
module wdt_bcd_counter #(
    parameter int NDIG = 4,
    localparam int CW = NDIG * wdt_pkg::DIGIT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          at_one
);
    import wdt_pkg::*;

    logic [CW-1:0]   cnt_q;
    logic [CW-1:0]   cnt_dec;
    logic [NDIG-1:0] borrow;

    assign borrow[0] = 1'b1;

    // Per-digit decrement with borrow into the next digit up.
    generate
        for (genvar g = 0; g < NDIG; g++) begin : g_digit
            logic [3:0] d;
            assign d = cnt_q[g*DIGIT_W +: DIGIT_W];
            assign cnt_dec[g*DIGIT_W +: DIGIT_W] =
                !borrow[g] ? d : ((d == 4'd0) ? BCD_MAX : d - 4'd1);
            if (g < NDIG - 1) begin : g_borrow
                assign borrow[g+1] = borrow[g] & (d == 4'd0);
            end
        end
    endgenerate

    assign at_one = (cnt_q == CW'(1));
    assign cnt    = cnt_q;

    // Count register: reset, load or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (dec)  cnt_q <= cnt_dec;
    end

    assert_load_takes_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(load_val));
    assert_dec_moves_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |=> cnt_q != $past(cnt_q));
    assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_interval_regs.sv
// Interval register file: NREG bytes of BCD, held by software.
// Shows the stored value and the value it will hold after this cycle's write.
// A write to any interval byte raises retrig. Addresses at and above NREG belong elsewhere.
module wdt_interval_regs #(
    parameter int NREG = 2,
    parameter int AW   = 2,
    localparam int RW = NREG * wdt_pkg::BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wr_data,
    output logic [RW-1:0] reload_q,
    output logic [RW-1:0] reload_nxt,
    output logic          retrig
);
    import wdt_pkg::*;

    assign retrig = wr_en && (addr < AW'(NREG));

    // Merge the write byte into the stored interval.
    generate
        for (genvar g = 0; g < NREG; g++) begin : g_byte
            assign reload_nxt[g*BYTE_W +: BYTE_W] =
                (retrig && addr == AW'(g)) ? wr_data : reload_q[g*BYTE_W +: BYTE_W];
        end
    endgenerate

    // Interval storage.
    always_ff @(posedge clk) begin
        if (!rst_n)      reload_q <= '0;
        else if (retrig) reload_q <= reload_nxt;
    end

    assert_write_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        retrig |=> reload_q == $past(reload_nxt));
    assert_no_write_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !retrig |=> $stable(reload_q));
endmodule

// File: rtl/wdt_flag_ctrl.sv
// Timeout flag and interrupt mask.
// If a timeout and a clear request fall in the same cycle, the timeout wins, so no event is lost.
// Assumes timeout is already gated off during interval writes.
module wdt_flag_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic timeout,
    input  logic retrig,
    input  logic rd_clr,
    input  logic mask_we,
    input  logic mask_d,
    output logic flag,
    output logic mask,
    output logic irq
);
    // Flag: set on timeout, cleared by retrigger or acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                flag <= 1'b0;
        else if (timeout)          flag <= 1'b1;
        else if (retrig || rd_clr) flag <= 1'b0;
    end

    // Mask: masked out of reset, changed only by a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= 1'b1;
        else if (mask_we) mask <= mask_d;
    end

    assign irq = flag & ~mask;

    assert_timeout_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> flag);
    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !timeout) |=> !flag);
    assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we && mask_d) |=> !irq);
endmodule

// File: rtl/wdt_interval_timer.sv
// Top level of the retriggerable watchdog interval timer.
// Counts 100 Hz ticks down from a BCD interval in hundredths of a second, flags each
// expiry and reloads. NDIG must be even (two digits per register byte).
// Map: addresses 0..NREG-1 are the interval bytes (low first), address NREG is control.
module wdt_interval_timer #(
    parameter int NDIG = 4,
    parameter int AW   = $clog2(NDIG / 2 + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wr_data,
    output logic [7:0]    rd_data,
    output logic          timeout_flag,
    output logic          irq
);
    import wdt_pkg::*;

    localparam int NREG = NDIG / 2;
    localparam int CW   = NDIG * DIGIT_W;

    logic [CW-1:0] reload_q, reload_nxt, cnt;
    logic          retrig, at_one, enabled, timeout_evt, dec, load;
    logic          ctrl_sel, mask;
    logic [7:0]    ctrl_byte;
    logic [7:0]    byte_view [NREG];

    u_regs_unused_guard: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |-> (NDIG % 2 == 0));

    wdt_interval_regs #(.NREG(NREG), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .reload_q(reload_q), .reload_nxt(reload_nxt), .retrig(retrig)
    );

    // Countdown sequencing: a write reloads, expiry reloads, otherwise decrement.
    assign enabled     = (reload_q != '0);
    assign timeout_evt = tick && enabled && at_one && !retrig;
    assign dec         = tick && enabled && !at_one && !retrig;
    assign load        = retrig || timeout_evt;

    wdt_bcd_counter #(.NDIG(NDIG)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load),
        .load_val(retrig ? reload_nxt : reload_q),
        .dec(dec), .cnt(cnt), .at_one(at_one)
    );

    assign ctrl_sel = (addr == AW'(NREG));

    wdt_flag_ctrl u_flag (
        .clk(clk), .rst_n(rst_n), .timeout(timeout_evt), .retrig(retrig),
        .rd_clr(rd_en && ctrl_sel), .mask_we(wr_en && ctrl_sel),
        .mask_d(wr_data[CTRL_MASK_BIT]), .flag(timeout_flag), .mask(mask), .irq(irq)
    );

    // Read-back view of the interval bytes.
    generate
        for (genvar g = 0; g < NREG; g++) begin : g_view
            assign byte_view[g] = reload_q[g*BYTE_W +: BYTE_W];
        end
    endgenerate

    // Control byte assembly.
    always_comb begin
        ctrl_byte = '0;
        ctrl_byte[CTRL_MASK_BIT] = mask;
        ctrl_byte[CTRL_FLAG_BIT] = timeout_flag;
    end

    // Read data select.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++)
            if (addr == AW'(i)) rd_data = byte_view[i];
        if (ctrl_sel) rd_data = ctrl_byte;
    end

    assert_write_clears_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        retrig |=> !timeout_flag);
    assert_disabled_never_fires_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |=> !$rose(timeout_flag));
    assert_ctrl_write_keeps_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ctrl_sel && !tick) |=> timeout_flag == $past(timeout_flag));
    assert_count_not_zero_when_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
        enabled |-> cnt != '0);
endmodule

// File: tb/test_wdt_interval_timer.sv
// Bench: a table of intervals walked by one loop, then directed tests.
module test_wdt_interval_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       timeout_flag, irq;
    int         n_cmp = 0, n_bad = 0;

    always #2 clk = ~clk;

    wdt_interval_timer i_wdt_interval_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .timeout_flag(timeout_flag), .irq(irq)
    );

    // {high byte (seconds), low byte (fraction)}
    localparam logic [15:0] VEC [8] = '{16'h0001, 16'h0005, 16'h0010, 16'h0099,
                                        16'h0100, 16'h0250, 16'h1000, 16'h9999};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rd_data;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    function automatic int bcd_val(input logic [15:0] v);
        return v[15:12]*1000 + v[11:8]*100 + v[7:4]*10 + v[3:0];
    endfunction

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 flag", timeout_flag, 0);
        check("R1 irq", irq, 0);
        rd(2'd0, d); check("R1 low byte", d, 8'h00);
        rd(2'd1, d); check("R1 high byte", d, 8'h00);
        rd(2'd2, d); check("R1 control", d, 8'h01);

        // R7 zero interval never fires
        ticks(300);
        check("R7 zero interval", timeout_flag, 0);

        // R2 byte storage
        wr(2'd0, 8'h37); rd(2'd0, d); check("R2 low byte", d, 8'h37);
        wr(2'd1, 8'h42); rd(2'd1, d); check("R2 high byte", d, 8'h42);
        wr(2'd2, 8'h00);

        // R3 R4 R5 table walk
        foreach (VEC[k]) begin
            n = bcd_val(VEC[k]);
            wr(2'd0, VEC[k][7:0]);
            wr(2'd1, VEC[k][15:8]);
            ticks(n - 1);
            check($sformatf("R3 early %04h", VEC[k]), timeout_flag, 0);
            ticks(1);
            check($sformatf("R4 expiry %04h", VEC[k]), timeout_flag, 1);
            check("R9 irq unmasked", irq, 1);
            rd(2'd2, d); check("R8 control read", d, 8'h02);
            check("R8 cleared", timeout_flag, 0);
            ticks(n - 1);
            check($sformatf("R5 early %04h", VEC[k]), timeout_flag, 0);
            ticks(1);
            check($sformatf("R5 repeat %04h", VEC[k]), timeout_flag, 1);
        end

        // R6 write restarts count and clears flag
        wr(2'd1, 8'h00); check("R6 write clears", timeout_flag, 0);
        wr(2'd0, 8'h05);
        ticks(3);
        wr(2'd0, 8'h05);
        ticks(4); check("R6 restarted early", timeout_flag, 0);
        ticks(1); check("R6 restarted expiry", timeout_flag, 1);

        // R10 / R9 control write only touches the mask
        wr(2'd0, 8'h03);
        ticks(2);
        wr(2'd2, 8'h01);
        check("R10 no flag change", timeout_flag, 0);
        ticks(1);
        check("R10 count not restarted", timeout_flag, 1);
        check("R9 masked irq", irq, 0);
        wr(2'd2, 8'h00);
        check("R10 flag kept", timeout_flag, 1);
        check("R9 unmasked irq", irq, 1);

        // R11 write wins over a simultaneous tick
        wr(2'd0, 8'h02);
        ticks(1);
        @(negedge clk); wr_en = 1'b1; addr = 2'd0; wr_data = 8'h02; tick = 1'b1;
        @(negedge clk); wr_en = 1'b0; tick = 1'b0;
        check("R11 no expiry on write", timeout_flag, 0);
        ticks(1); check("R11 tick not counted", timeout_flag, 0);
        ticks(1); check("R11 expiry", timeout_flag, 1);

        // R7 writing zeros disables the timer
        wr(2'd0, 8'h00);
        ticks(500);
        check("R7 disabled again", timeout_flag, 0);

        finish_run();
    end
endmodule